// File: doc/BRIEF.md
# Region-Based External Bus Wait-State Generator

This block lengthens external bus accesses by a programmed number of machine cycles. For each access, the processor side presents a start pulse, the access kind (program, data or I/O) and the address. The block picks a 3-bit base count from a configuration word according to the address region. It can double that count, and then holds the bus stalled while it counts the inserted cycles down. When two or more software waits are in force, the block follows those waits with the external ready input. It also drives an active-low microstate-complete output that marks the span of the software waits.

The configuration word has five 3-bit fields. Bits 2:0 serve lower program space and bits 5:3 serve upper program space. Bits 8:6 serve lower data (address bit 15 clear) and bits 11:9 serve upper data (address bit 15 set). Bits 14:12 serve I/O space. Bit 15 is a program-decode mode bit. A second, one-bit word holds the multiplier. Both words are loaded through a small write port. The count is captured when an access starts, so a write that arrives during an access is seen only by later accesses.

Top module: `wait_state_gen`

## Requirements
- R1: After reset, every region field holds 7 and the multiplier is clear, so a data access takes 7 stall cycles. Bus stall and access done are low, and microstate-complete (msc_n) is high.
- R2: Data accesses use bits 11:9 when address bit 15 is 1 and bits 8:6 when it is 0. I/O accesses (space code 2 or 3) use bits 14:12.
- R3: Program accesses with mode bit 15 at 0 use bits 5:3 when address bit 15 is 1 and bits 2:0 when it is 0, whatever address bits 19:16 hold.
- R4: Program accesses with mode bit 15 at 1 always use bits 2:0, and bits 5:3 then have no effect.
- R5: With the multiplier bit (word select 1, data bit 0) set, the wait count is twice the base count, up to 14.
- R6: When ready is high, bus_stall is high for exactly N cycles after the base cycle, and acc_done pulses in the last of them.
- R7: With N = 0, acc_done is high in the base cycle itself, bus_stall stays low, ext_ready is ignored and msc_n stays high.
- R8: When N >= 2, ext_ready is sampled in the last software wait and then once per cycle. Each low sample adds one stall cycle.
- R9: When N = 1, ext_ready is ignored and the access ends after one wait.
- R10: When N >= 2, msc_n is low for the first N-1 wait cycles and high from the last software wait onward. Otherwise it stays high.
- R11: A configuration write during an access does not change that access's length. It applies from the next access.
- R12: A start pulse during an access is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Machine clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0: region word, 1: multiplier word |
| cfg_wdata | input | 16 | Configuration write data |
| acc_start | input | 1 | Access begins in this (base) cycle |
| acc_space | input | 2 | 0 program, 1 data, 2/3 I/O |
| acc_addr | input | 20 | Access address |
| ext_ready | input | 1 | External device ready |
| bus_stall | output | 1 | High in every inserted cycle |
| acc_done | output | 1 | High in the final cycle of the access |
| msc_n | output | 1 | Active-low microstate-complete |

## Verification
On every cycle, the assertions check these properties:
- A stall, once begun, lasts until a done pulse, and each done ends it.
- msc_n is never low outside a stall.
- A zero count finishes in the base cycle.
- A single wait ends after one cycle.
- A low ready sample during the ready phase never completes the access.

Only the bench scenarios can show that region decode picks the correct field and that the multiplier doubles the count. The scenarios also show the exact number of ready-extension cycles, the exact span of msc_n, and that mid-access writes and start pulses leave the running access unchanged.

// File: rtl/ws_pkg.sv
package ws_pkg;
  parameter int unsigned WS_FIELD_W = 3;
  parameter int unsigned WS_ADDR_W  = 20;
  parameter int unsigned WS_HALF_BIT = 15;

  typedef enum logic [1:0] {
    SP_PROG = 2'd0,
    SP_DATA = 2'd1,
    SP_IO   = 2'd2,
    SP_IO2  = 2'd3
  } space_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SWAIT = 2'd1,
    ST_RWAIT = 2'd2
  } ws_state_e;
endpackage

// File: rtl/ws_cfg.sv
module ws_cfg #(
  parameter int unsigned FIELD_W = ws_pkg::WS_FIELD_W,
  localparam int unsigned CFG_W = 5 * FIELD_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             sel,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] region,
  output logic             mult
);
  // Reset: mode bit clear, every field at its maximum base count.
  localparam logic [CFG_W-1:0] REGION_RST = {1'b0, {(CFG_W-1){1'b1}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      region <= REGION_RST;
      mult   <= 1'b0;
    end else if (we) begin
      if (!sel) region <= wdata;
      else      mult   <= wdata[0];
    end
  end
endmodule

// File: rtl/ws_decode.sv
module ws_decode #(
  parameter int unsigned FIELD_W  = ws_pkg::WS_FIELD_W,
  parameter int unsigned ADDR_W   = ws_pkg::WS_ADDR_W,
  parameter int unsigned HALF_BIT = ws_pkg::WS_HALF_BIT,
  localparam int unsigned CFG_W = 5 * FIELD_W + 1,
  localparam int unsigned CNT_W = FIELD_W + 1
) (
  input  logic [CFG_W-1:0]  region,
  input  logic              mult,
  input  ws_pkg::space_e    space,
  input  logic [ADDR_W-1:0] addr,
  output logic [CNT_W-1:0]  n_waits
);
  localparam int unsigned F_PLO = 0;
  localparam int unsigned F_PHI = 1;
  localparam int unsigned F_DLO = 2;
  localparam int unsigned F_DHI = 3;
  localparam int unsigned F_IO  = 4;
  localparam int unsigned MODE_BIT = 5 * FIELD_W;

  function automatic int unsigned field_index(ws_pkg::space_e sp, logic upper, logic flat);
    case (sp)
      ws_pkg::SP_PROG: field_index = (flat || !upper) ? F_PLO : F_PHI;
      ws_pkg::SP_DATA: field_index = upper ? F_DHI : F_DLO;
      default:         field_index = F_IO;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] scale(logic [FIELD_W-1:0] base, logic dbl);
    scale = dbl ? {base, 1'b0} : {1'b0, base};
  endfunction

  logic [FIELD_W-1:0] fields [5];
  for (genvar k = 0; k < 5; k++) begin : g_field
    assign fields[k] = region[k*FIELD_W +: FIELD_W];
  end

  logic [FIELD_W-1:0] base_cnt;
  always_comb begin
    base_cnt = fields[field_index(space, addr[HALF_BIT], region[MODE_BIT])];
    n_waits  = scale(base_cnt, mult);
  end
endmodule

// File: rtl/ws_counter.sv
module ws_counter #(
  parameter int unsigned FIELD_W = ws_pkg::WS_FIELD_W,
  localparam int unsigned CNT_W = FIELD_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] n_waits,
  input  logic             ready,
  output logic             idle,
  output logic             stall,
  output logic             done,
  output logic             msc_n,
  output logic             rdy_chk
);
  import ws_pkg::*;

  ws_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic             rdy_en;
  logic             last_sw;

  assign idle    = (state == ST_IDLE);
  assign stall   = !idle;
  assign last_sw = (state == ST_SWAIT) && (cnt == CNT_W'(1));
  assign rdy_chk = (last_sw && rdy_en) || (state == ST_RWAIT);
  assign msc_n   = !((state == ST_SWAIT) && (cnt > CNT_W'(1)));
  assign done    = (idle && start && (n_waits == '0))
                 || (last_sw && (!rdy_en || ready))
                 || ((state == ST_RWAIT) && ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      rdy_en <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start && (n_waits != '0)) begin
          state  <= ST_SWAIT;
          cnt    <= n_waits;
          rdy_en <= (n_waits >= CNT_W'(2));
        end
        ST_SWAIT: begin
          if (cnt > CNT_W'(1)) cnt <= cnt - CNT_W'(1);
          else if (rdy_en && !ready) state <= ST_RWAIT;
          else state <= ST_IDLE;
        end
        ST_RWAIT: if (ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wait_state_gen.sv
module wait_state_gen #(
  parameter int unsigned FIELD_W  = ws_pkg::WS_FIELD_W,
  parameter int unsigned ADDR_W   = ws_pkg::WS_ADDR_W,
  parameter int unsigned HALF_BIT = ws_pkg::WS_HALF_BIT,
  localparam int unsigned CFG_W = 5 * FIELD_W + 1,
  localparam int unsigned CNT_W = FIELD_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              acc_start,
  input  logic [1:0]        acc_space,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              ext_ready,
  output logic              bus_stall,
  output logic              acc_done,
  output logic              msc_n
);
  logic [CFG_W-1:0] region;
  logic             mult;
  logic [CNT_W-1:0] n_waits;
  logic             idle_w;
  logic             start_ok;
  logic             rdy_chk;

  ws_cfg #(.FIELD_W(FIELD_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
    .wdata(cfg_wdata), .region(region), .mult(mult)
  );

  ws_decode #(.FIELD_W(FIELD_W), .ADDR_W(ADDR_W), .HALF_BIT(HALF_BIT)) u_dec (
    .region(region), .mult(mult), .space(ws_pkg::space_e'(acc_space)),
    .addr(acc_addr), .n_waits(n_waits)
  );

  assign start_ok = acc_start && idle_w;

  ws_counter #(.FIELD_W(FIELD_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .start(acc_start), .n_waits(n_waits),
    .ready(ext_ready), .idle(idle_w), .stall(bus_stall), .done(acc_done),
    .msc_n(msc_n), .rdy_chk(rdy_chk)
  );
endmodule

// File: rtl/ws_checker.sv
module ws_checker #(
  parameter int unsigned CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_ok,
  input logic [CNT_W-1:0] n_waits,
  input logic             ext_ready,
  input logic             rdy_chk,
  input logic             bus_stall,
  input logic             acc_done,
  input logic             msc_n
);
  // R7: zero count finishes in the base cycle without stalling
  a_r7_zero_done_now: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ok && n_waits == '0) |-> (acc_done && !bus_stall && msc_n));

  // R9: a single wait ends one cycle later regardless of ready
  a_r9_single_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ok && n_waits == CNT_W'(1)) |=> (bus_stall && acc_done));

  // R6: stall persists until done, and done ends it
  a_r6_stall_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_stall && !acc_done) |=> bus_stall);
  a_r6_done_ends_stall: assert property (@(posedge clk) disable iff (!rst_n)
    acc_done |=> !bus_stall);

  // R10: msc_n low only inside a stall, never in the final cycle
  a_r10_msc_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
    !msc_n |-> (bus_stall && !acc_done));

  // R8: a low ready sample in the ready phase never completes the access
  a_r8_ready_low_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_chk && !ext_ready) |-> !acc_done);
endmodule

bind wait_state_gen ws_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_ok(start_ok), .n_waits(n_waits),
  .ext_ready(ext_ready), .rdy_chk(rdy_chk), .bus_stall(bus_stall),
  .acc_done(acc_done), .msc_n(msc_n)
);

// File: tb/sim_wait_state_gen.sv
module sim_wait_state_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        acc_start = 1'b0;
  logic [1:0]  acc_space = '0;
  logic [19:0] acc_addr = '0;
  logic        ext_ready = 1'b1;
  logic        bus_stall, acc_done, msc_n;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wait_state_gen u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .acc_start(acc_start), .acc_space(acc_space),
    .acc_addr(acc_addr), .ext_ready(ext_ready), .bus_stall(bus_stall),
    .acc_done(acc_done), .msc_n(msc_n)
  );

  typedef struct packed {
    logic [15:0] region;
    logic        mult;
    logic [1:0]  space;
    logic [19:0] addr;
    logic [3:0]  nsw;
    logic [2:0]  llow;
  } vec_t;

  // Region word 58D1: io=5, data hi=4, data lo=3, prog hi=2, prog lo=1.
  localparam vec_t VECS [9] = '{
    '{16'h58D1, 1'b0, 2'd1, 20'h09000, 4'd4, 3'd2},  // R2 R8 data upper
    '{16'h58D1, 1'b0, 2'd1, 20'h00100, 4'd3, 3'd0},  // R2 data lower
    '{16'h58D1, 1'b0, 2'd2, 20'h0FFFF, 4'd5, 3'd1},  // R2 io
    '{16'h58D1, 1'b0, 2'd3, 20'h00000, 4'd5, 3'd0},  // R2 io alt code
    '{16'h58D1, 1'b0, 2'd0, 20'hA8000, 4'd2, 3'd1},  // R3 prog upper
    '{16'h58D1, 1'b0, 2'd0, 20'h37FFF, 4'd1, 3'd3},  // R3 R9 prog lower
    '{16'hD8D1, 1'b0, 2'd0, 20'hA8000, 4'd1, 3'd0},  // R4 flat program
    '{16'hD8D1, 1'b1, 2'd0, 20'h0C000, 4'd2, 3'd0},  // R4 R5
    '{16'h08D1, 1'b0, 2'd2, 20'h00010, 4'd0, 3'd2}   // R7 zero waits
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic sel, input logic [15:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Runs one access; ready is low for the first llow samples after the
  // software waits. If poke is set, a zeroing config write and a stray
  // start pulse are applied in the second wait cycle.
  task automatic do_access(input logic [1:0] sp, input logic [19:0] ad,
                           input int nsw, input int llow, input bit poke,
                           input string req);
    int exp_total, stall_cnt, msc_low;
    bit done_seen, done_stalled;
    exp_total = nsw + ((nsw >= 2) ? llow : 0);
    @(negedge clk);
    acc_space = sp; acc_addr = ad; acc_start = 1'b1; ext_ready = 1'b0;
    #1;
    if (nsw == 0) begin
      check(acc_done && !bus_stall && msc_n, req, "zero-wait base cycle done",
            int'(acc_done), 1);
      @(negedge clk);
      acc_start = 1'b0; ext_ready = 1'b1;
      #1;
      check(!bus_stall && !acc_done, req, "idle after zero-wait", int'(bus_stall), 0);
      return;
    end
    check(!acc_done && !bus_stall, req, "base cycle not stalled", int'(bus_stall), 0);
    stall_cnt = 0; msc_low = 0; done_seen = 0; done_stalled = 0;
    for (int g = 0; g < 40 && !done_seen; g++) begin
      @(negedge clk);
      acc_start = 1'b0;
      cfg_we = 1'b0;
      ext_ready = ((stall_cnt + 1) >= (nsw + llow));
      if (poke && stall_cnt == 1) begin
        cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 16'h0000;
        acc_start = 1'b1; acc_space = 2'd1; acc_addr = 20'h00000;
      end
      #1;
      if (bus_stall) stall_cnt++;
      if (!msc_n) msc_low++;
      if (acc_done) begin
        done_seen = 1;
        done_stalled = bus_stall;
      end
    end
    @(negedge clk);
    acc_start = 1'b0; cfg_we = 1'b0; ext_ready = 1'b1;
    #1;
    check(stall_cnt == exp_total, req, "stall cycles", stall_cnt, exp_total);
    check(done_seen && done_stalled, req, "done in last stall cycle (R6)",
          int'(done_seen), 1);
    check(msc_low == ((nsw >= 2) ? nsw - 1 : 0), {req, " R10"}, "msc_n low cycles",
          msc_low, (nsw >= 2) ? nsw - 1 : 0);
    check(!bus_stall, req, "idle after done", int'(bus_stall), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(!bus_stall && !acc_done && msc_n, "R1", "reset outputs", int'(bus_stall), 0);
    rst_n = 1'b1;

    // R1: defaults give seven waits everywhere
    do_access(2'd1, 20'h08000, 7, 0, 1'b0, "R1");
    do_access(2'd0, 20'h00000, 7, 1, 1'b0, "R1");

    // Table walk
    foreach (VECS[i]) begin
      cfg_write(1'b0, VECS[i].region);
      cfg_write(1'b1, {15'd0, VECS[i].mult});
      do_access(VECS[i].space, VECS[i].addr, int'(VECS[i].nsw),
                int'(VECS[i].llow), 1'b0, "R2 R3 R4 R9");
    end

    // R4: mode bit set, upper program field changed, still uses lower field
    cfg_write(1'b1, 16'h0000);
    cfg_write(1'b0, 16'hFFC3);   // prog lo=3, prog hi=0
    do_access(2'd0, 20'hF8000, 3, 0, 1'b0, "R4");

    // R5: multiplier on reset-style word gives fourteen
    cfg_write(1'b0, 16'h7FFF);
    cfg_write(1'b1, 16'h0001);
    do_access(2'd2, 20'h00000, 14, 2, 1'b0, "R5 R8");
    cfg_write(1'b1, 16'h0000);

    // R11 R12: zeroing write plus stray start mid-access keep length 7
    do_access(2'd1, 20'h00000, 7, 0, 1'b1, "R11 R12");
    do_access(2'd1, 20'h00000, 0, 0, 1'b0, "R11");

    // R7: zero waits with ready held low still completes
    do_access(2'd0, 20'h00000, 0, 3, 1'b0, "R7");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule